// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Tile

This block is a single tile of a simple configurable logic fabric. It holds two lookup tables. Each table has three inputs and two outputs. Together with fixed wiring inside the tile, the pair behaves as four 3-input lookup tables. The first table reads inputs a, b and c. The second table reads d, e and f. In carry mode, the second table reads the carry input from the neighbouring tile in place of f. The second output of the second table also leaves the tile as the carry output. Chained arithmetic therefore passes from tile to tile without using general routing.

All the truth tables and the mode bit sit in one 33-bit shift chain, which is loaded one bit per clock while the load enable is high. The last bit of the chain appears on a serial output, so tiles can be daisy-chained into one long configuration path. While loading is in progress, every logic output is held at zero, so a half-written configuration never drives the fabric.

Top module: `cfg_lut_tile`

## Requirements
- R1: After reset the configuration chain is all zero, so every logic output, the carry output and the serial output read 0.
- R2: On each clock with cfg_en high, the chain shifts up one place and cfg_in enters bit 0; cfg_out always shows bit 32, so the first of 33 loaded bits ends in bit 32.
- R3: With cfg_en low the chain holds its contents, and the outputs keep following the stored tables.
- R4: While cfg_en is high, out1, out2, out3, out4 and carry_out are all 0.
- R5: With cfg_en low, out1 equals chain bit {c,b,a} and out2 equals chain bit 8+{c,b,a}, where the index is c*4+b*2+a.
- R6: With cfg_en low and bit 32 clear, out3 equals chain bit 16+{f,e,d} and out4 equals chain bit 24+{f,e,d}.
- R7: With bit 32 set (carry mode), carry_in takes the place of f in the second table's index, and in_f has no effect.
- R8: With bit 32 clear, carry_in has no effect on any output.
- R9: carry_out always equals out4, so a full-adder sum and carry can be built from the table contents alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (chain bit 32) |
| in_a | input | 1 | First table input, index bit 0 |
| in_b | input | 1 | First table input, index bit 1 |
| in_c | input | 1 | First table input, index bit 2 |
| in_d | input | 1 | Second table input, index bit 0 |
| in_e | input | 1 | Second table input, index bit 1 |
| in_f | input | 1 | Second table input, index bit 2 (outside carry mode) |
| carry_in | input | 1 | Carry from the adjacent tile |
| out1 | output | 1 | First table, output 0 |
| out2 | output | 1 | First table, output 1 |
| out3 | output | 1 | Second table, output 0 |
| out4 | output | 1 | Second table, output 1 |
| carry_out | output | 1 | Carry to the adjacent tile (same as out4) |

## Verification
The bench loads several configurations with unrelated table contents, then sweeps all 64 input combinations with both carry-in values. A reversed index or a swapped table would make an output track the wrong entry. A mode bit that was ignored, or that was applied backwards, would let in_f leak through in carry mode or let carry_in leak through outside it. Outputs are compared during loading itself, where a missing gate would expose partial tables. cfg_out is compared on every cycle, which catches an off-by-one chain length or a reversed shift direction. A full-adder configuration is then driven through carry-in, where a wrong carry tap would corrupt the carry output.

// File: rtl/cfg_lut_tile.sv
module cfg_lut_tile #(
  parameter int K = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic cfg_in,
  output logic cfg_out,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  input  logic in_d,
  input  logic in_e,
  input  logic in_f,
  input  logic carry_in,
  output logic out1,
  output logic out2,
  output logic out3,
  output logic out4,
  output logic carry_out
);
  localparam int ENT = 1 << K;
  localparam int CW  = 4 * ENT + 1;

  logic [CW-1:0]  chain;
  logic [K-1:0]   sel_a, sel_b;
  logic [ENT-1:0] t1, t2, t3, t4;
  logic           carry_mode, r1, r2, r3, r4;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      chain <= '0;
    else if (cfg_en) chain <= {chain[CW-2:0], cfg_in};

  assign cfg_out    = chain[CW-1];
  assign carry_mode = chain[CW-1];

  assign t1 = chain[0*ENT +: ENT];
  assign t2 = chain[1*ENT +: ENT];
  assign t3 = chain[2*ENT +: ENT];
  assign t4 = chain[3*ENT +: ENT];

  assign sel_a = {in_c, in_b, in_a};
  assign sel_b = {carry_mode ? carry_in : in_f, in_e, in_d};

  assign r1 = t1[sel_a];
  assign r2 = t2[sel_a];
  assign r3 = t3[sel_b];
  assign r4 = t4[sel_b];

  assign out1      = r1 & ~cfg_en;
  assign out2      = r2 & ~cfg_en;
  assign out3      = r3 & ~cfg_en;
  assign out4      = r4 & ~cfg_en;
  assign carry_out = out4;
endmodule

module cfg_lut_tile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en,
  input logic        cfg_in,
  input logic        cfg_out,
  input logic [32:0] chain,
  input logic        out1,
  input logic        out2,
  input logic        out3,
  input logic        out4,
  input logic        carry_out
);
  // R4
  outputs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> ({out1, out2, out3, out4, carry_out} == 5'b0));
  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> chain[0] == $past(cfg_in));
  // R2
  shift_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_out == $past(chain[31]));
  // R3
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(chain));
  // R9
  carry_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == out4);
endmodule

bind cfg_lut_tile cfg_lut_tile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
  .cfg_out(cfg_out), .chain(chain), .out1(out1), .out2(out2),
  .out3(out3), .out4(out4), .carry_out(carry_out)
);

// File: tb/tb_cfg_lut_tile.sv
module tb_cfg_lut_tile;
  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_in = 0;
  logic in_a = 0, in_b = 0, in_c = 0, in_d = 0, in_e = 0, in_f = 0, carry_in = 0;
  logic cfg_out, out1, out2, out3, out4, carry_out;
  int checks = 0, errors = 0;
  string tag = "R1";
  bit mq[$];

  always #2 clk = ~clk;

  cfg_lut_tile dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d), .in_e(in_e), .in_f(in_f),
    .carry_in(carry_in), .out1(out1), .out2(out2), .out3(out3), .out4(out4),
    .carry_out(carry_out)
  );

  task automatic cmp(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    int ia, ib, fsel;
    bit e1, e2, e3, e4;
    string rq;
    ia   = in_c * 4 + in_b * 2 + in_a;
    fsel = mq[32] ? int'(carry_in) : int'(in_f);
    ib   = fsel * 4 + in_e * 2 + in_d;
    e1 = cfg_en ? 0 : mq[ia];
    e2 = cfg_en ? 0 : mq[8 + ia];
    e3 = cfg_en ? 0 : mq[16 + ib];
    e4 = cfg_en ? 0 : mq[24 + ib];
    rq = cfg_en ? "R4" : tag;
    cmp(rq, "out1", out1, e1);
    cmp(rq, "out2", out2, e2);
    cmp(rq, "out3", out3, e3);
    cmp(rq, "out4", out4, e4);
    cmp(cfg_en ? "R4" : "R9", "carry_out", carry_out, e4);
    cmp(tag == "R1" ? "R1" : "R2", "cfg_out", cfg_out, mq[32]);
  endtask

  task automatic step(bit en, bit din, int ins, bit cin);
    @(negedge clk);
    cfg_en = en; cfg_in = din; carry_in = cin;
    {in_f, in_e, in_d, in_c, in_b, in_a} = ins[5:0];
    #1 check_all();
    @(posedge clk);
    if (en) begin
      mq.push_front(din);
      void'(mq.pop_back());
    end
  endtask

  task automatic load(logic [32:0] w);
    tag = "R2";
    for (int i = 32; i >= 0; i--) step(1, w[i], (i * 7) & 63, i[0]);
  endtask

  task automatic sweep(string t);
    tag = t;
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 64; v++) step(0, v[0], v, c[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 33; i++) mq.push_back(0);
    #1 tag = "R1";
    check_all();
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0);
    step(0, 1, 63, 1);
    // R5 R6 R8: plain mode, carry_in swept and must not matter
    load({1'b0, 8'h3C, 8'hA5, 8'h96, 8'h5A});
    sweep("R6");
    load({1'b0, 8'h01, 8'h80, 8'hF0, 8'h0F});
    sweep("R5");
    sweep("R8");
    // R7: carry mode, in_f swept and must not matter
    load({1'b1, 8'hC3, 8'h69, 8'h17, 8'hE2});
    sweep("R7");
    // R3: idle cycles with cfg_in toggling leave the tables intact
    tag = "R3";
    for (int i = 0; i < 20; i++) step(0, i[0], 63 - i, i[1]);
    sweep("R3");
    // R9: full adder over {carry_in,e,d}: sum 0x96, carry 0xE8
    load({1'b1, 8'hE8, 8'h96, 8'hE8, 8'h96});
    sweep("R9");
    // R2: chain content shifts out of cfg_out intact
    tag = "R2";
    for (int i = 0; i < 40; i++) step(1, i[2] ^ i[0], i & 63, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule